// File: doc/BRIEF.md
# Card Slot Controller Power-State Manager

This block holds the device power state of a card-slot bus controller and shapes the controller's outward behaviour to match it. Software writes a request that targets either the controller itself or the power state recorded for the attached card. Each request is checked against the current state. A legal request is applied on the next clock edge. An illegal one leaves every state unchanged and raises a one-cycle error pulse.

In the fully-on state, card interrupts pass to the system, the processor may reach the cards, and slot power follows its software control bit. In the two intermediate states, all interrupts are masked and card access is refused. Slot power is frozen at the value it had on entry. A card status-change event can still raise a bus wake level if wake is enabled. In the deepest state, the clock enable and slot power are off and context is marked lost. Only the bus reset leaves it, and that reset restores every power-on default.

Top module: `pwr_state_mgr`

## Requirements
- R1: While the controller state is D0, `sysIrq` is high whenever `cardStsChg` or `cardFuncIrq` is high, and `accessOk` and `clkEn` are high.
- R2: While the controller state is D0, `slotPwrEn` equals `slotPwrCtl` in the same cycle.
- R3: While the controller state is D1 or D2, `sysIrq` and `accessOk` are low whatever the interrupt inputs do, and `ctxValid` keeps its value.
- R4: In D1 or D2, a cycle with `cardStsChg` and `wakeEn` both high sets `busWake` after that clock edge. With `wakeEn` low, `busWake` is not set. `busWake` stays high until a `wakeClr` pulse or an accepted move to D0 clears it.
- R5: When the controller enters D1 or D2 from D0, `slotPwrEn` takes the value of `slotPwrCtl` at that edge. It then holds that value while the state stays in D1 or D2, including moves between them, whatever `slotPwrCtl` does.
- R6: In D3, `clkEn`, `slotPwrEn`, `ctxValid` and `busWake` are low, and status-change events raise nothing.
- R7: While `busRstN` is low, and after it rises, the controller and card states are D0, `busWake` and `reqErr` are low, and `ctxValid` is low. This holds from any state.
- R8: `ctxValid` is set only by an `initDone` pulse outside D3. Entry to D3 clears it. `initDone` has no effect in D3.
- R9: While the controller is in D1 or D2, the card state is never D0. A card request for D0 in D1/D2 is rejected. A controller request for D1 or D2 while the card state is D0 is rejected.
- R10: A request is a `reqValid` cycle. `reqCard` 0 targets the controller and 1 targets the card. `reqState` uses D0=0, D1=1, D2=2, D3=3. A rejected request leaves both states unchanged and makes `reqErr` high for exactly the cycle after it. The following requests are rejected: any request while in D3 (D3 is left only by bus reset), a controller request for D1 when `HAS_D1` is 0, a controller request for D2 when `HAS_D2` is 0, and the cases in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| busRstN | input | 1 | Bus reset, active low, asynchronous; restores defaults |
| reqValid | input | 1 | Power-state request strobe |
| reqCard | input | 1 | Request target: 0 controller, 1 card |
| reqState | input | 2 | Requested state, D0=0 .. D3=3 |
| cardStsChg | input | 1 | Card status-change interrupt source |
| cardFuncIrq | input | 1 | Card functional interrupt source |
| wakeEn | input | 1 | Wake enable |
| wakeClr | input | 1 | Software clear of the wake level |
| slotPwrCtl | input | 1 | Software slot power control bit |
| initDone | input | 1 | Software reinitialisation complete pulse |
| curState | output | 2 | Current controller power state |
| cardState | output | 2 | Recorded card power state |
| reqErr | output | 1 | One-cycle pulse after a rejected request |
| sysIrq | output | 1 | Interrupt to the system |
| busWake | output | 1 | Bus wake request level |
| slotPwrEn | output | 1 | Slot power enable |
| clkEn | output | 1 | Controller clock enable |
| accessOk | output | 1 | Processor access to cards allowed |
| ctxValid | output | 1 | Controller context valid |

## Verification
If the state register is wrong, `sysIrq`, `accessOk` and `clkEn` disagree with the requested state in the same cycle the request commits. This shows right after the edge that applied it. A stale slot latch or wake flag shows as soon as `slotPwrCtl` toggles or a status-change event arrives while the state is low. A wrong legality decision shows as a `reqErr` pulse that is missing or unexpected one cycle after the request, together with an unchanged or changed `curState`/`cardState`.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    PS_D0 = 2'd0,
    PS_D1 = 2'd1,
    PS_D2 = 2'd2,
    PS_D3 = 2'd3
  } pstate_t;

  typedef struct packed {
    logic enterLow;
    logic enterD0;
    logic enterD3;
  } strobe_t;

  function automatic logic isLow(input logic [1:0] s);
    return (s == PS_D1) || (s == PS_D2);
  endfunction
endpackage

// File: rtl/psm_ctrl.sv
module psm_ctrl
  import pwr_pkg::*;
#(
  parameter bit HAS_D1 = 1'b1,
  parameter bit HAS_D2 = 1'b1
) (
  input  logic       clk,
  input  logic       busRstN,
  input  logic       reqValid,
  input  logic       reqCard,
  input  logic [1:0] reqState,
  output logic [1:0] curState,
  output logic [1:0] cardState,
  output logic       reqErr,
  output strobe_t    stb
);
  logic supported;
  logic ctrlOk;
  logic cardOk;
  logic badReq;

  always_comb begin
    unique case (reqState)
      PS_D1:   supported = HAS_D1;
      PS_D2:   supported = HAS_D2;
      default: supported = 1'b1;
    endcase
    ctrlOk = reqValid && !reqCard && (curState != PS_D3) && supported &&
             !(isLow(reqState) && (cardState == PS_D0));
    cardOk = reqValid && reqCard && (curState != PS_D3) &&
             !(isLow(curState) && (reqState == PS_D0));
    badReq = reqValid && !ctrlOk && !cardOk;
    stb.enterLow = ctrlOk && isLow(reqState) && !isLow(curState);
    stb.enterD0  = ctrlOk && (reqState == PS_D0) && (curState != PS_D0);
    stb.enterD3  = ctrlOk && (reqState == PS_D3) && (curState != PS_D3);
  end

  always_ff @(posedge clk or negedge busRstN) begin
    if (!busRstN) begin
      curState  <= PS_D0;
      cardState <= PS_D0;
      reqErr    <= 1'b0;
    end else begin
      reqErr <= badReq;
      if (ctrlOk) curState  <= reqState;
      if (cardOk) cardState <= reqState;
    end
  end
endmodule

// File: rtl/psm_datapath.sv
module psm_datapath
  import pwr_pkg::*;
(
  input  logic       clk,
  input  logic       busRstN,
  input  strobe_t    stb,
  input  logic [1:0] curState,
  input  logic       cardStsChg,
  input  logic       cardFuncIrq,
  input  logic       wakeEn,
  input  logic       wakeClr,
  input  logic       slotPwrCtl,
  input  logic       initDone,
  output logic       sysIrq,
  output logic       busWake,
  output logic       slotPwrEn,
  output logic       clkEn,
  output logic       accessOk,
  output logic       ctxValid
);
  logic slotHeld;
  logic lowNow;
  logic onNow;

  assign lowNow = isLow(curState);
  assign onNow  = (curState == PS_D0);

  always_ff @(posedge clk or negedge busRstN) begin
    if (!busRstN) begin
      slotHeld <= 1'b0;
      busWake  <= 1'b0;
      ctxValid <= 1'b0;
    end else begin
      if (stb.enterLow) slotHeld <= slotPwrCtl;
      if (stb.enterD0 || stb.enterD3 || wakeClr) busWake <= 1'b0;
      else if (lowNow && cardStsChg && wakeEn) busWake <= 1'b1;
      if (stb.enterD3) ctxValid <= 1'b0;
      else if (initDone && (curState != PS_D3)) ctxValid <= 1'b1;
    end
  end

  always_comb begin
    sysIrq    = onNow && (cardStsChg || cardFuncIrq);
    accessOk  = onNow;
    clkEn     = (curState != PS_D3);
    slotPwrEn = onNow ? slotPwrCtl : (lowNow ? slotHeld : 1'b0);
  end
endmodule

// File: rtl/pwr_state_mgr.sv
module pwr_state_mgr
  import pwr_pkg::*;
#(
  parameter bit HAS_D1 = 1'b1,
  parameter bit HAS_D2 = 1'b1
) (
  input  logic       clk,
  input  logic       busRstN,
  input  logic       reqValid,
  input  logic       reqCard,
  input  logic [1:0] reqState,
  input  logic       cardStsChg,
  input  logic       cardFuncIrq,
  input  logic       wakeEn,
  input  logic       wakeClr,
  input  logic       slotPwrCtl,
  input  logic       initDone,
  output logic [1:0] curState,
  output logic [1:0] cardState,
  output logic       reqErr,
  output logic       sysIrq,
  output logic       busWake,
  output logic       slotPwrEn,
  output logic       clkEn,
  output logic       accessOk,
  output logic       ctxValid
);
  strobe_t stb;

  psm_ctrl #(.HAS_D1(HAS_D1), .HAS_D2(HAS_D2)) uCtrl (
    .clk(clk), .busRstN(busRstN), .reqValid(reqValid), .reqCard(reqCard),
    .reqState(reqState), .curState(curState), .cardState(cardState),
    .reqErr(reqErr), .stb(stb)
  );

  psm_datapath uData (
    .clk(clk), .busRstN(busRstN), .stb(stb), .curState(curState),
    .cardStsChg(cardStsChg), .cardFuncIrq(cardFuncIrq), .wakeEn(wakeEn),
    .wakeClr(wakeClr), .slotPwrCtl(slotPwrCtl), .initDone(initDone),
    .sysIrq(sysIrq), .busWake(busWake), .slotPwrEn(slotPwrEn),
    .clkEn(clkEn), .accessOk(accessOk), .ctxValid(ctxValid)
  );
endmodule

// File: rtl/psm_checker.sv
module psm_checker (
  input logic       clk,
  input logic       busRstN,
  input logic [1:0] curState,
  input logic [1:0] cardState,
  input logic       sysIrq,
  input logic       busWake,
  input logic       slotPwrEn,
  input logic       clkEn,
  input logic       accessOk,
  input logic       ctxValid
);
  logic lowNow;
  assign lowNow = (curState == 2'd1) || (curState == 2'd2);

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!busRstN)
    (curState != 2'd0) |-> !sysIrq); // R3

  AST_D3_ALL_OFF: assert property (@(posedge clk) disable iff (!busRstN)
    (curState == 2'd3) |-> (!clkEn && !slotPwrEn && !ctxValid && !busWake)); // R6

  AST_SLOT_FROZEN: assert property (@(posedge clk) disable iff (!busRstN)
    (lowNow && (($past(curState) == 2'd1) || ($past(curState) == 2'd2)))
      |-> $stable(slotPwrEn)); // R5

  AST_CARD_NOT_D0: assert property (@(posedge clk) disable iff (!busRstN)
    lowNow |-> (cardState != 2'd0)); // R9

  AST_NO_D3_EXIT: assert property (@(posedge clk) disable iff (!busRstN)
    ($past(curState) == 2'd3) |-> (curState == 2'd3)); // R10

  AST_ACCESS_ON_ONLY: assert property (@(posedge clk) disable iff (!busRstN)
    accessOk |-> ((curState == 2'd0) && clkEn)); // R1
endmodule

bind pwr_state_mgr psm_checker uChk (
  .clk(clk), .busRstN(busRstN), .curState(curState), .cardState(cardState),
  .sysIrq(sysIrq), .busWake(busWake), .slotPwrEn(slotPwrEn), .clkEn(clkEn),
  .accessOk(accessOk), .ctxValid(ctxValid)
);

// File: tb/pwr_state_mgr_test.sv
`timescale 1ns/1ps
module pwr_state_mgr_test;
  logic clk = 1'b0;
  logic busRstN = 1'b0;
  logic reqValid = 1'b0, reqCard = 1'b0;
  logic [1:0] reqState = 2'd0;
  logic cardStsChg = 1'b0, cardFuncIrq = 1'b0, wakeEn = 1'b0, wakeClr = 1'b0;
  logic slotPwrCtl = 1'b0, initDone = 1'b0;
  logic [1:0] curState, cardState, curStateB, cardStateB;
  logic reqErr, sysIrq, busWake, slotPwrEn, clkEn, accessOk, ctxValid;
  logic reqErrB, sysIrqB, busWakeB, slotPwrEnB, clkEnB, accessOkB, ctxValidB;
  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pwr_state_mgr uut (
    .clk(clk), .busRstN(busRstN), .reqValid(reqValid), .reqCard(reqCard),
    .reqState(reqState), .cardStsChg(cardStsChg), .cardFuncIrq(cardFuncIrq),
    .wakeEn(wakeEn), .wakeClr(wakeClr), .slotPwrCtl(slotPwrCtl),
    .initDone(initDone), .curState(curState), .cardState(cardState),
    .reqErr(reqErr), .sysIrq(sysIrq), .busWake(busWake), .slotPwrEn(slotPwrEn),
    .clkEn(clkEn), .accessOk(accessOk), .ctxValid(ctxValid)
  );

  pwr_state_mgr #(.HAS_D2(1'b0)) uutNoD2 (
    .clk(clk), .busRstN(busRstN), .reqValid(reqValid), .reqCard(reqCard),
    .reqState(reqState), .cardStsChg(cardStsChg), .cardFuncIrq(cardFuncIrq),
    .wakeEn(wakeEn), .wakeClr(wakeClr), .slotPwrCtl(slotPwrCtl),
    .initDone(initDone), .curState(curStateB), .cardState(cardStateB),
    .reqErr(reqErrB), .sysIrq(sysIrqB), .busWake(busWakeB), .slotPwrEn(slotPwrEnB),
    .clkEn(clkEnB), .accessOk(accessOkB), .ctxValid(ctxValidB)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic request(input logic card, input logic [1:0] st);
    @(negedge clk);
    reqValid = 1'b1; reqCard = card; reqState = st;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic pulseStsChg();
    @(negedge clk); cardStsChg = 1'b1;
    @(negedge clk); cardStsChg = 1'b0;
  endtask

  task automatic pulseInit();
    @(negedge clk); initDone = 1'b1;
    @(negedge clk); initDone = 1'b0;
  endtask

  task automatic testReset();
    chk("R7 state", curState, 0);
    chk("R7 card", cardState, 0);
    chk("R7 ctx", ctxValid, 0);
    chk("R7 wake", busWake, 0);
    chk("R7 err", reqErr, 0);
    chk("R7 clkEn", clkEn, 1);
  endtask

  task automatic testInitAndOn();
    pulseInit();
    chk("R8 ctx set", ctxValid, 1);
    cardStsChg = 1'b1; #1;
    chk("R1 sts irq", sysIrq, 1);
    cardStsChg = 1'b0; cardFuncIrq = 1'b1; #1;
    chk("R1 func irq", sysIrq, 1);
    chk("R1 access", accessOk, 1);
    cardFuncIrq = 1'b0;
    slotPwrCtl = 1'b1; #1;
    chk("R2 slot on", slotPwrEn, 1);
    slotPwrCtl = 1'b0; #1;
    chk("R2 slot off", slotPwrEn, 0);
  endtask

  task automatic testCardRule();
    request(1'b0, 2'd1);
    chk("R9 low with card D0 err", reqErr, 1);
    chk("R9 state kept", curState, 0);
    @(negedge clk);
    chk("R10 err one cycle", reqErr, 0);
    request(1'b1, 2'd3);
    chk("R10 card write ok", reqErr, 0);
    chk("R10 card state", cardState, 3);
  endtask

  task automatic testD1();
    slotPwrCtl = 1'b1;
    request(1'b0, 2'd1);
    chk("R3 state D1", curState, 1);
    chk("R3 access off", accessOk, 0);
    chk("R3 ctx kept", ctxValid, 1);
    chk("R5 slot captured", slotPwrEn, 1);
    slotPwrCtl = 1'b0; #1;
    chk("R5 slot held", slotPwrEn, 1);
    cardStsChg = 1'b1; cardFuncIrq = 1'b1; #1;
    chk("R3 irq masked", sysIrq, 0);
    @(negedge clk); cardStsChg = 1'b0; cardFuncIrq = 1'b0;
    chk("R4 no wake when disabled", busWake, 0);
    wakeEn = 1'b1;
    pulseStsChg();
    chk("R4 wake set", busWake, 1);
    @(negedge clk);
    chk("R4 wake level held", busWake, 1);
    @(negedge clk); wakeClr = 1'b1;
    @(negedge clk); wakeClr = 1'b0;
    chk("R4 wake cleared", busWake, 0);
    request(1'b1, 2'd0);
    chk("R9 card D0 rejected", reqErr, 1);
    chk("R9 card state kept", cardState, 3);
  endtask

  task automatic testD2AndBack();
    request(1'b0, 2'd2);
    chk("R3 state D2", curState, 2);
    chk("R10 unsupported D2 err", reqErrB, 1);
    chk("R10 unsupported kept D1", curStateB, 1);
    chk("R5 slot held into D2", slotPwrEn, 1);
    pulseStsChg();
    chk("R4 wake in D2", busWake, 1);
    request(1'b0, 2'd0);
    chk("R1 back to D0", curState, 0);
    chk("R4 wake cleared by D0", busWake, 0);
    chk("R2 slot follows ctl", slotPwrEn, 0);
    chk("R1 access back", accessOk, 1);
  endtask

  task automatic testD3();
    slotPwrCtl = 1'b1;
    request(1'b0, 2'd3);
    chk("R6 state D3", curState, 3);
    chk("R6 clk off", clkEn, 0);
    chk("R6 slot off", slotPwrEn, 0);
    chk("R6 ctx lost", ctxValid, 0);
    pulseStsChg();
    chk("R6 no wake", busWake, 0);
    pulseInit();
    chk("R8 init ignored in D3", ctxValid, 0);
    request(1'b0, 2'd0);
    chk("R10 D3 write err", reqErr, 1);
    chk("R10 stays D3", curState, 3);
  endtask

  task automatic testBusReset();
    @(negedge clk); busRstN = 1'b0;
    @(negedge clk); busRstN = 1'b1;
    @(negedge clk);
    chk("R7 state D0", curState, 0);
    chk("R7 card D0", cardState, 0);
    chk("R7 ctx low", ctxValid, 0);
    chk("R7 clk on", clkEn, 1);
    chk("R2 slot after reset", slotPwrEn, 1);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    busRstN = 1'b1;
    @(negedge clk);
    testReset();
    testInitAndOn();
    testCardRule();
    testD1();
    testD2AndBack();
    testD3();
    testBusReset();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule